// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is a general-purpose I/O port of up to 32 pins behind a small register bus made of an address, a write strobe with write data, and a read strobe with registered read data. Each pin has an output value bit and a direction bit. Each pin's direction bit also serves as its pad output enable. Software reads the synchronized state of the pads through a read-only register.

Every pin also has an interrupt source. It has a two-bit trigger code, an enable bit and a sticky pending bit. Pads are brought into the clock domain through a short synchronizer chain before any level or edge is judged. Pending bits are cleared by writing ones. A single request line goes high while any enabled pin has a pending bit.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output value, direction, both trigger-code and enable registers read 0, pad_out and pad_oe are 0, and irq is 0.
- R2: The output value register sits at offset 0x00. A write there drives pad_out for bit n = pin n on the next cycle, and the register reads back the written value.
- R3: The direction register sits at offset 0x04. A 1 in bit n makes pin n an output, and pad_oe bit n equals that bit on the next cycle.
- R4: Offset 0x08 reads the pad inputs after the synchronizer, not the output value register. Writes to it are ignored.
- R5: Trigger codes are two-bit fields. Pins 0 to 15 sit in the register at offset 0x0C and pins 16 to 31 in the one at offset 0x10. Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)], and both registers read back.
- R6: Code 0 (low level) and code 1 (high level) set the pin's pending bit on every cycle the synchronized level holds, so a clear has no lasting effect while that level stays.
- R7: Code 2 (rising edge) and code 3 (falling edge) set the pending bit once per matching synchronized transition. Once cleared, the bit stays clear while the pad is steady.
- R8: Pending bits are at offset 0x18. Writing a 1 to bit n clears pin n's bit, and a 0 leaves it as it was.
- R9: When a trigger and a clear for the same pin fall in the same cycle, the pending bit ends up set.
- R10: The enable register sits at offset 0x14, with 1 meaning enabled. irq is high exactly when some pin is both pending and enabled.
- R11: Offsets outside the seven registers read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; read data updates on the next edge |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NPIN | Pad input levels, asynchronous |
| pad_out | output | NPIN | Pad output values |
| pad_oe | output | NPIN | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench places a clear in the exact cycle that a rising edge reaches the pending register. A design in which the clear takes priority would lose that event and read the bit back as 0. It clears a pin while its level trigger is still active. A design that treats levels as edges would read 0 there, when the bit must come back set. It sets a trigger in the upper code register and a pin at the field boundary. Swapped registers or shifted fields would make the wrong pin pend or no pin pend. It also writes to the read-only pad offset and to an unmapped offset, where a loose address decode would corrupt a neighbouring register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      TRG_LOW  = 2'd0,
      TRG_HIGH = 2'd1,
      TRG_RISE = 2'd2,
      TRG_FALL = 2'd3
   } trig_e;

   localparam int unsigned REG_W          = 32;
   localparam int unsigned CODE_W         = 2;
   localparam int unsigned CODES_PER_WORD = REG_W / CODE_W;

   localparam logic [7:0] OFS_DOUT   = 8'h00;
   localparam logic [7:0] OFS_DIR    = 8'h04;
   localparam logic [7:0] OFS_PAD    = 8'h08;
   localparam logic [7:0] OFS_CFG_LO = 8'h0C;
   localparam logic [7:0] OFS_CFG_HI = 8'h10;
   localparam logic [7:0] OFS_MASK   = 8'h14;
   localparam logic [7:0] OFS_STAT   = 8'h18;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);

   // STAGES flops of synchronization plus one history flop for edges
   localparam int unsigned DEPTH = STAGES + 1;

   logic [W-1:0] stg [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      end
   end

   assign q      = stg[STAGES-1];
   assign q_prev = stg[STAGES];

endmodule

// File: rtl/gpio_trig_eval.sv
module gpio_trig_eval
   import gpio_irq_pkg::*;
(
   input  trig_e mode,
   input  logic  cur,
   input  logic  prev,
   output logic  hit
);

   always_comb begin
      unique case (mode)
         TRG_LOW:  hit = ~cur;
         TRG_HIGH: hit = cur;
         TRG_RISE: hit = cur & ~prev;
         TRG_FALL: hit = ~cur & prev;
         default:  hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN        = 32,
   parameter int unsigned AW          = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_we,
   input  logic [31:0]      bus_wdata,
   input  logic             bus_re,
   output logic [31:0]      bus_rdata,
   input  logic [NPIN-1:0]  pad_in,
   output logic [NPIN-1:0]  pad_out,
   output logic [NPIN-1:0]  pad_oe,
   output logic             irq
);

   localparam int unsigned CFG_W = 2 * REG_W;

   function automatic logic [CFG_W-1:0] low_ones(input int unsigned n);
      logic [CFG_W-1:0] r;
      for (int i = 0; i < CFG_W; i++) r[i] = (i < n);
      return r;
   endfunction

   localparam logic [REG_W-1:0] PIN_MASK = REG_W'(low_ones(NPIN));
   localparam logic [CFG_W-1:0] CFG_MASK = low_ones(CODE_W * NPIN);

   // elaboration-time parameter checks
   if (NPIN < 1 || NPIN > REG_W) begin : g_bad_npin
      $error("gpio_irq_port: NPIN must lie in 1..32");
   end
   if (AW < 5 || AW > 8) begin : g_bad_aw
      $error("gpio_irq_port: AW must lie in 5..8");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("gpio_irq_port: SYNC_STAGES must lie in 2..4");
   end

   logic [REG_W-1:0] dout_q, dir_q, mask_q, stat_q;
   logic [CFG_W-1:0] cfg_q;
   logic [REG_W-1:0] rdata_q, rd_d;
   logic [REG_W-1:0] evt, clr;
   logic [NPIN-1:0]  pad_s, pad_p;

   // ---------------- input synchronization ----------------
   gpio_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (pad_in),
      .q      (pad_s),
      .q_prev (pad_p)
   );

   // ---------------- per-pin trigger evaluation ----------------
   for (genvar g = 0; g < REG_W; g++) begin : g_pin
      if (g < NPIN) begin : g_live
         gpio_trig_eval u_trig (
            .mode (trig_e'(cfg_q[CODE_W*g +: CODE_W])),
            .cur  (pad_s[g]),
            .prev (pad_p[g]),
            .hit  (evt[g])
         );
      end else begin : g_absent
         assign evt[g] = 1'b0;
      end
   end

   // ---------------- register decode ----------------
   function automatic logic at(input logic [AW-1:0] a, input logic [7:0] ofs);
      return a == ofs[AW-1:0];
   endfunction

   logic wr_dout, wr_dir, wr_lo, wr_hi, wr_mask, wr_stat;
   assign wr_dout = bus_we && at(bus_addr, OFS_DOUT);
   assign wr_dir  = bus_we && at(bus_addr, OFS_DIR);
   assign wr_lo   = bus_we && at(bus_addr, OFS_CFG_LO);
   assign wr_hi   = bus_we && at(bus_addr, OFS_CFG_HI);
   assign wr_mask = bus_we && at(bus_addr, OFS_MASK);
   assign wr_stat = bus_we && at(bus_addr, OFS_STAT);

   assign clr = wr_stat ? (bus_wdata & PIN_MASK) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '0;
         mask_q <= '0;
         stat_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (wr_dout) dout_q <= bus_wdata & PIN_MASK;
         if (wr_dir)  dir_q  <= bus_wdata & PIN_MASK;
         if (wr_mask) mask_q <= bus_wdata & PIN_MASK;
         if (wr_lo)   cfg_q[REG_W-1:0]     <= bus_wdata & CFG_MASK[REG_W-1:0];
         if (wr_hi)   cfg_q[CFG_W-1:REG_W] <= bus_wdata & CFG_MASK[CFG_W-1:REG_W];
         // a new event is ORed in after the clear, so it is never lost
         stat_q <= (stat_q & ~clr) | evt;
      end
   end

   // ---------------- read path ----------------
   always_comb begin
      rd_d = '0;
      if      (at(bus_addr, OFS_DOUT))   rd_d = dout_q;
      else if (at(bus_addr, OFS_DIR))    rd_d = dir_q;
      else if (at(bus_addr, OFS_PAD))    rd_d = REG_W'(pad_s);
      else if (at(bus_addr, OFS_CFG_LO)) rd_d = cfg_q[REG_W-1:0];
      else if (at(bus_addr, OFS_CFG_HI)) rd_d = cfg_q[CFG_W-1:REG_W];
      else if (at(bus_addr, OFS_MASK))   rd_d = mask_q;
      else if (at(bus_addr, OFS_STAT))   rd_d = stat_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_re) rdata_q <= rd_d;
   end

   assign bus_rdata = rdata_q;
   assign pad_out   = dout_q[NPIN-1:0];
   assign pad_oe    = dir_q[NPIN-1:0];
   assign irq       = |(stat_q & mask_q);

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN = 32,
   parameter int unsigned AW   = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:0]   bus_addr,
   input logic            bus_we,
   input logic [31:0]     bus_wdata,
   input logic [NPIN-1:0] pad_out,
   input logic [NPIN-1:0] pad_oe,
   input logic            irq,
   input logic [31:0]     stat,
   input logic [31:0]     evt
);

   logic w_dout, w_dir, w_mask, w_stat;
   assign w_dout = bus_we && (bus_addr == OFS_DOUT[AW-1:0]);
   assign w_dir  = bus_we && (bus_addr == OFS_DIR[AW-1:0]);
   assign w_mask = bus_we && (bus_addr == OFS_MASK[AW-1:0]);
   assign w_stat = bus_we && (bus_addr == OFS_STAT[AW-1:0]);

   p_dout_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      w_dout |=> pad_out == $past(bus_wdata[NPIN-1:0]));

   p_dir_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      w_dir |=> pad_oe == $past(bus_wdata[NPIN-1:0]));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !w_stat |=> (($past(stat) & ~stat) == 32'd0));

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> (($past(evt) & ~stat) == 32'd0));

   p_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (w_mask && bus_wdata[NPIN-1:0] == '0) |=> !irq);

   p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat != 32'd0));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq       (irq),
   .stat      (stat_q),
   .evt       (evt)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;

   localparam int NPIN = 32;
   localparam int AW   = 5;
   localparam logic [AW-1:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                             A_LO = 5'h0C, A_HI = 5'h10, A_MASK = 5'h14,
                             A_STAT = 5'h18, A_NONE = 5'h1C;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic            bus_we = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic            bus_re = 1'b0;
   logic [31:0]     bus_rdata;
   logic [NPIN-1:0] pad_in = '0;
   logic [NPIN-1:0] pad_out, pad_oe;
   logic            irq;

   int n_run = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic [31:0] act_q [$];

   always #2.5 clk = ~clk;

   gpio_irq_port #(.NPIN(NPIN), .AW(AW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      act_q.push_back(bus_rdata);
      bus_re = 1'b0;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
      n_run++;
      if (act !== e) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, e);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // monitor: pops expected items and compares with returned read data
   initial begin
      forever begin
         wait (act_q.size() != 0);
         chk(act_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_run++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk({31'd0, irq}, 32'd0, "R1 irq");
      chk(pad_oe, 32'd0, "R1 pad_oe");
      chk(pad_out, 32'd0, "R1 pad_out");
      rd(A_DOUT, 32'd0, "R1 dout");
      rd(A_DIR,  32'd0, "R1 dir");
      rd(A_LO,   32'd0, "R1 cfg lo");
      rd(A_HI,   32'd0, "R1 cfg hi");
      rd(A_MASK, 32'd0, "R1 mask");

      // R2 output value, R3 direction
      wr(A_DOUT, 32'hA5A5_0F0F);
      chk(pad_out, 32'hA5A5_0F0F, "R2 pad_out");
      rd(A_DOUT, 32'hA5A5_0F0F, "R2 readback");
      wr(A_DIR, 32'hFFFF_0000);
      chk(pad_oe, 32'hFFFF_0000, "R3 pad_oe");
      rd(A_DIR, 32'hFFFF_0000, "R3 readback");

      // R4 pad status
      pad_in = 32'h1234_5678;
      settle();
      rd(A_PAD, 32'h1234_5678, "R4 pad read");
      wr(A_PAD, 32'hFFFF_FFFF);
      rd(A_PAD, 32'h1234_5678, "R4 write ignored");

      // R5 trigger codes: rising for pins 0-15, falling for 16-31
      wr(A_LO, 32'hAAAA_AAAA);
      wr(A_HI, 32'hFFFF_FFFF);
      rd(A_LO, 32'hAAAA_AAAA, "R5 lo readback");
      rd(A_HI, 32'hFFFF_FFFF, "R5 hi readback");
      pad_in = '0;
      settle();
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, 32'd0, "R8 clear all");

      // R7 rising edge on pin 3
      pad_in = 32'h0000_0008;
      settle();
      rd(A_STAT, 32'h0000_0008, "R7 rising pin3");
      wr(A_STAT, 32'd0);
      rd(A_STAT, 32'h0000_0008, "R8 zero write keeps");
      wr(A_STAT, 32'h0000_0008);
      settle();
      rd(A_STAT, 32'd0, "R7 edge stays clear");

      // R7/R5 falling edge on pin 20 (upper register)
      pad_in = 32'h0010_0008;
      settle();
      rd(A_STAT, 32'd0, "R7 rise ignored in fall mode");
      pad_in = 32'h0000_0008;
      settle();
      rd(A_STAT, 32'h0010_0000, "R7 falling pin20");

      // R10 enable and request line
      chk({31'd0, irq}, 32'd0, "R10 masked");
      wr(A_MASK, 32'h0010_0000);
      chk({31'd0, irq}, 32'd1, "R10 enabled");
      wr(A_MASK, 32'h0000_0020);
      chk({31'd0, irq}, 32'd0, "R10 other pin enabled");
      rd(A_MASK, 32'h0000_0020, "R10 mask readback");
      wr(A_MASK, 32'h0010_0000);
      wr(A_STAT, 32'h0010_0000);
      chk({31'd0, irq}, 32'd0, "R10 cleared");

      // R6 high level on pin 17 (field bits 3:2 of upper register = 1)
      wr(A_HI, 32'hFFFF_FFF7);
      pad_in = 32'h0002_0008;
      settle();
      wr(A_STAT, 32'h0002_0000);
      rd(A_STAT, 32'h0002_0000, "R6 high level resets");
      pad_in = 32'h0000_0008;
      settle();
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, 32'd0, "R6 level gone");

      // R6 low level on pin 2 (field bits 5:4 of lower register = 0)
      wr(A_LO, 32'hAAAA_AA8A);
      settle();
      wr(A_STAT, 32'h0000_0004);
      rd(A_STAT, 32'h0000_0004, "R6 low level resets");
      pad_in = 32'h0000_000C;
      settle();
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, 32'd0, "R6 low level gone");

      // R9 clear in the same cycle as the rising edge of pin 5
      pad_in = 32'h0000_002C;
      @(negedge clk);
      @(negedge clk);
      wr(A_STAT, 32'h0000_0020);
      rd(A_STAT, 32'h0000_0020, "R9 set wins");
      wr(A_STAT, 32'h0000_0020);
      rd(A_STAT, 32'd0, "R8 plain clear");

      // R11 unmapped offset
      wr(A_NONE, 32'hDEAD_BEEF);
      rd(A_NONE, 32'd0, "R11 unmapped reads 0");
      rd(A_DOUT, 32'hA5A5_0F0F, "R11 dout untouched");
      rd(A_MASK, 32'h0010_0000, "R11 mask untouched");

      wait (act_q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule